// File: doc/BRIEF.md
# Repeating Status Byte Serial Shifter

This block answers the status-read command of a serial flash slave. It oversamples the serial pins (chip select, serial clock, serial data in) on the system clock and collects the 8-bit opcode, most significant bit first. When the opcode is one of the two status-read codes, it returns an 8-bit status byte on the serial output. The byte starts on the serial-clock falling edge that follows the last opcode bit.

The byte goes out most significant bit first and repeats for as long as the host keeps clocking. Each repetition takes a fresh copy of the compare-result flag. The ready bit is never latched: it follows the busy input live. A host can therefore stop the serial clock low while the ready bit is on the wire and wait for the output to rise. The busy and compare flags come from other logic and pass through a synchroniser before use. The density code is a parameter, and the two low bits are driven 0. When chip select is high the output is not driven, and the next transaction starts opcode decoding from scratch.

Top module: `status_shifter`

## Requirements
- R1: While chip select has been high for at least 4 system clocks, `so_oe` is 0 and `so` is 0. This also holds after reset.
- R2: After the exact 8-bit opcode 57h or D7h, sampled on rising serial-clock edges MSB first, `so_oe` rises on the next falling serial-clock edge, and the first bit driven is bit 7.
- R3: Any other opcode, including one that differs from a status code in a single bit, leaves `so_oe` at 0 for the rest of that transaction.
- R4: Bit 7 equals the inverse of `busy` and follows it live while bit 7 is on the output, including while the serial clock is halted low.
- R5: Bit 6 equals `cmp_diff` as sampled on the falling edge that starts the repetition. Later changes to `cmp_diff` appear only in the next repetition.
- R6: Bits 5 to 2 are the density code 1,0,1,1 (bit 5 first), and bits 1 and 0 are 0.
- R7: Each falling edge moves the output one bit lower. After bit 0, the next falling edge starts again at bit 7, for as long as chip select stays low.
- R8: A rising chip select ends the transaction at any point, whether during the opcode or during the output. The next transaction decodes its opcode afresh.
- R9: The command works with the serial clock idling low (mode 0) and with it idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| busy | input | 1 | Device busy flag from internal logic |
| cmp_diff | input | 1 | Last page/buffer compare mismatched |
| so | output | 1 | Serial data out (0 when not driven) |
| so_oe | output | 1 | Output enable for the serial data pad |

## Verification
Two cases are hard to reach from the ports, because each needs an input change placed between two particular serial-clock edges. The first is the live ready bit while the serial clock is halted. The second is a compare flag that changes partway through a byte. The bench drives the serial clock itself in half-periods of several system clocks. At chosen points it stops the clock low on bit 7 and toggles `busy`, checking the output after each change. It also changes `cmp_diff` right after bit 7 has been read, then checks that bit 6 in that byte keeps the old value and that the next byte shows the new one. Random transactions mix both clock modes, status and non-status opcodes, and several repetitions per transaction.

// File: rtl/status_shifter_pkg.sv
package status_shifter_pkg;

    localparam int OPC_W  = 8;
    localparam int CNT_W  = $clog2(OPC_W);
    localparam int STAT_W = 8;
    localparam int IDX_W  = $clog2(STAT_W);

    typedef enum logic [1:0] {
        PH_OPC    = 2'd0,
        PH_ARMED  = 2'd1,
        PH_SHIFT  = 2'd2,
        PH_IGNORE = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [OPC_W-2:0]   hist;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic               comp_cap;
        logic               sck_prev;
    } shf_state_t;

endpackage

// File: rtl/status_sync.sv
module status_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/status_opc_match.sv
module status_opc_match #(
    parameter int                  OPC_W = 8,
    parameter int                  N     = 2,
    parameter logic [N*OPC_W-1:0]  CODES = {8'hD7, 8'h57}
) (
    input  logic [OPC_W-1:0] opc,
    output logic             hit
);
    logic [N-1:0] hits;

    for (genvar k = 0; k < N; k++) begin : g_code
        assign hits[k] = (opc == CODES[k*OPC_W +: OPC_W]);
    end

    assign hit = |hits;
endmodule

// File: rtl/status_byte_fmt.sv
module status_byte_fmt #(
    parameter int                STAT_W  = 8,
    parameter int                DENS_W  = 4,
    parameter int                IDX_W   = $clog2(STAT_W),
    parameter logic [DENS_W-1:0] DENSITY = 4'b1011
) (
    input  logic             ready,
    input  logic             comp,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    localparam int RSV_W = STAT_W - 2 - DENS_W;

    logic [STAT_W-1:0] stat_byte;

    assign stat_byte = {ready, comp, DENSITY, {RSV_W{1'b0}}};
    assign bit_o     = stat_byte[idx];
endmodule

// File: rtl/status_shifter.sv
module status_shifter
    import status_shifter_pkg::*;
#(
    parameter int                  SYNC_STAGES  = 2,
    parameter int                  N_STAT_OPC   = 2,
    parameter logic [N_STAT_OPC*OPC_W-1:0] STAT_OPCODES = {8'hD7, 8'h57},
    parameter int                  DENS_W       = 4,
    parameter logic [DENS_W-1:0]   DENSITY      = 4'b1011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic busy,
    input  logic cmp_diff,
    output logic so,
    output logic so_oe
);
    localparam logic [CNT_W-1:0] LAST_OPC_BIT = CNT_W'(OPC_W - 1);
    localparam logic [IDX_W-1:0] TOP_BIT      = IDX_W'(STAT_W - 1);

    // pin synchronisers: cs idles high
    logic       cs_s, sck_s, si_s, busy_s, cmp_s;
    logic       rise, fall, hit, stat_bit;
    logic [OPC_W-1:0] opc_next;
    shf_state_t q, d;

    status_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, si}),
        .q     ({cs_s, sck_s, si_s})
    );

    status_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_flag_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({busy, cmp_diff}),
        .q     ({busy_s, cmp_s})
    );

    assign rise     = sck_s & ~q.sck_prev;
    assign fall     = ~sck_s & q.sck_prev;
    assign opc_next = {q.hist, si_s};

    status_opc_match #(.OPC_W(OPC_W), .N(N_STAT_OPC), .CODES(STAT_OPCODES)) u_match (
        .opc (opc_next),
        .hit (hit)
    );

    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        if (cs_s) begin
            d.phase = PH_OPC;
            d.hist  = '0;
            d.cnt   = '0;
            d.idx   = TOP_BIT;
        end else begin
            unique case (q.phase)
                PH_OPC: begin
                    if (rise) begin
                        d.hist = opc_next[OPC_W-2:0];
                        d.cnt  = q.cnt + 1'b1;
                        if (q.cnt == LAST_OPC_BIT) begin
                            d.phase = hit ? PH_ARMED : PH_IGNORE;
                        end
                    end
                end
                PH_ARMED: begin
                    if (fall) begin
                        d.phase    = PH_SHIFT;
                        d.idx      = TOP_BIT;
                        d.comp_cap = cmp_s;
                    end
                end
                PH_SHIFT: begin
                    if (fall) begin
                        if (q.idx == '0) begin
                            d.idx      = TOP_BIT;
                            d.comp_cap = cmp_s;
                        end else begin
                            d.idx = q.idx - 1'b1;
                        end
                    end
                end
                default: d.phase = PH_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase    <= PH_OPC;
            q.hist     <= '0;
            q.cnt      <= '0;
            q.idx      <= TOP_BIT;
            q.comp_cap <= 1'b0;
            q.sck_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    status_byte_fmt #(
        .STAT_W (STAT_W),
        .DENS_W (DENS_W),
        .IDX_W  (IDX_W),
        .DENSITY(DENSITY)
    ) u_fmt (
        .ready (~busy_s),
        .comp  (q.comp_cap),
        .idx   (q.idx),
        .bit_o (stat_bit)
    );

    assign so_oe = (q.phase == PH_SHIFT);
    assign so    = so_oe & stat_bit;

    // views for the bound checker
    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             comp_q;
    assign phase_q = q.phase;
    assign idx_q   = q.idx;
    assign comp_q  = q.comp_cap;

endmodule

// File: rtl/status_shifter_chk.sv
module status_shifter_chk
    import status_shifter_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_s,
    input logic             fall,
    input phase_e           phase_q,
    input logic [IDX_W-1:0] idx_q,
    input logic             comp_q,
    input logic             so_oe
);
    // R1
    cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_s) |-> !so_oe);

    // R2
    arm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> ($past(phase_q) == PH_ARMED) && $past(fall) && (idx_q == IDX_W'(STAT_W - 1)));

    // R3
    ignore_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IGNORE && !cs_s) |=> (phase_q == PH_IGNORE));

    // R5
    comp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHIFT && !fall && !cs_s) |=> $stable(comp_q));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHIFT && fall && !cs_s && idx_q == '0) |=> (idx_q == IDX_W'(STAT_W - 1)));

    // R7
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHIFT && fall && !cs_s && idx_q != '0) |=> (idx_q == $past(idx_q) - 1'b1));
endmodule

bind status_shifter status_shifter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .fall    (fall),
    .phase_q (phase_q),
    .idx_q   (idx_q),
    .comp_q  (comp_q),
    .so_oe   (so_oe)
);

// File: tb/sim_status_shifter.sv
`timescale 1ns/1ps
module sim_status_shifter;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n, cs_n, sck, si, busy, cmp_diff;
    logic so, so_oe;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic busy_cur, comp_cur;

    always #5 clk = ~clk;

    status_shifter u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .busy(busy), .cmp_diff(cmp_diff), .so(so), .so_oe(so_oe)
    );

    function automatic logic [7:0] exp_byte(input logic b, input logic c);
        return {~b, c, 4'b1011, 2'b00};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sck_rise();
        @(negedge clk); sck = 1'b1; wait_h();
    endtask

    task automatic sck_fall();
        @(negedge clk); sck = 1'b0; wait_h();
    endtask

    task automatic start_txn(input bit m3);
        @(negedge clk); cs_n = 1'b1; sck = m3; wait_h();
        cs_n = 1'b0; wait_h();
    endtask

    task automatic end_txn(input bit m3, input string tag);
        if (!m3 && sck) sck_fall();
        if (m3 && !sck) sck_rise();
        @(negedge clk); cs_n = 1'b1; wait_h();
        check({tag, " oe off after cs high"}, {7'd0, so_oe}, 8'd0);
        check({tag, " so low after cs high"}, {7'd0, so}, 8'd0);
    endtask

    task automatic send_bits(input logic [7:0] op, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            if (sck) sck_fall();
            si = op[i];
            wait_h();
            sck_rise();
        end
    endtask

    task automatic status_txn(input bit m3, input logic [7:0] op, input int nbytes, input bit rnd);
        logic [7:0] e;
        logic cap;
        start_txn(m3);
        send_bits(op, 8);
        for (int b = 0; b < nbytes; b++) begin
            if (rnd) begin busy_cur = 1'($urandom); busy = busy_cur; end
            cap = comp_cur;
            for (int i = 7; i >= 0; i--) begin
                sck_fall();
                e = exp_byte(busy_cur, cap);
                if (i == 7) begin
                    check(b == 0 ? "R2 R9 oe on first bit" : "R7 oe on repeat", {7'd0, so_oe}, 8'd1);
                    check(b == 0 ? "R4 bit7 first byte" : "R7 R4 bit7 repeat", {7'd0, so}, {7'd0, e[7]});
                    if (rnd) begin comp_cur = 1'($urandom); cmp_diff = comp_cur; end
                end else if (i == 6) begin
                    check("R5 bit6 captured compare", {7'd0, so}, {7'd0, e[6]});
                end else begin
                    check("R6 fixed bits", {7'd0, so}, {7'd0, e[i]});
                end
                sck_rise();
            end
        end
    endtask

    task automatic reject_txn(input bit m3, input logic [7:0] op);
        start_txn(m3);
        send_bits(op, 8);
        for (int i = 0; i < 10; i++) begin
            sck_fall();
            check("R3 other opcode stays quiet", {7'd0, so_oe}, 8'd0);
            sck_rise();
        end
        end_txn(m3, "R3");
    endtask

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
        busy = 1'b0; cmp_diff = 1'b0; busy_cur = 1'b0; comp_cur = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_h();
        check("R1 reset oe", {7'd0, so_oe}, 8'd0);
        check("R1 reset so", {7'd0, so}, 8'd0);

        // directed: mode 0 ready, mode 3 busy with compare change
        status_txn(1'b0, 8'h57, 2, 1'b0);
        end_txn(1'b0, "R1");
        busy = 1'b1; busy_cur = 1'b1; cmp_diff = 1'b1; comp_cur = 1'b1;
        status_txn(1'b1, 8'hD7, 3, 1'b1);
        end_txn(1'b1, "R9");

        // directed: near-miss opcodes
        reject_txn(1'b0, 8'h56);
        reject_txn(1'b1, 8'hD6);
        reject_txn(1'b0, 8'h17);
        reject_txn(1'b1, 8'h5F);

        // R8: abort in opcode, then full status
        start_txn(1'b0);
        send_bits(8'h57, 4);
        end_txn(1'b0, "R8 abort in opcode");
        status_txn(1'b0, 8'hD7, 1, 1'b1);
        // abort during output
        sck_fall();
        sck_rise();
        sck_fall();
        end_txn(1'b0, "R8 abort in output");
        status_txn(1'b1, 8'h57, 1, 1'b1);
        end_txn(1'b1, "R8");

        // R4: halt clock low on bit 7 and watch ready
        busy = 1'b1; busy_cur = 1'b1;
        status_txn(1'b0, 8'h57, 1, 1'b0);
        sck_fall();
        check("R4 halted bit7 busy", {7'd0, so}, 8'd0);
        @(negedge clk); busy = 1'b0;
        repeat (6) @(negedge clk);
        check("R4 halted bit7 ready rises", {7'd0, so}, 8'd1);
        @(negedge clk); busy = 1'b1;
        repeat (6) @(negedge clk);
        check("R4 halted bit7 busy again", {7'd0, so}, 8'd0);
        busy_cur = 1'b1;
        end_txn(1'b0, "R4");

        // random mix
        for (int t = 0; t < 24; t++) begin
            bit m3;
            logic [7:0] op;
            m3 = 1'($urandom);
            if ($urandom % 2 == 0) begin
                op = ($urandom % 2 == 0) ? 8'h57 : 8'hD7;
                status_txn(m3, op, 1 + int'($urandom % 3), 1'b1);
                end_txn(m3, "R1 R8");
            end else begin
                op = 8'($urandom);
                if (op == 8'h57 || op == 8'hD7) op = op ^ 8'h01;
                reject_txn(m3, op);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule